// File: doc/BRIEF.md
# Dual-Mode Control Register Port

This block is the control register file of a three-channel image digitizer front end. It holds one configuration word, an offset code for each colour channel and a gain code for each colour channel. Software in the host reaches these registers either over a parallel interface or over a three-wire serial interface. The two interfaces share a single bus with the converter's output samples.

Two inputs pick who uses the shared bus: a port-select input and a converter-output disable input. When the converter owns the bus, its 12-bit samples are driven onto every bus bit. In the parallel mode, a write takes the address from bus bits 10:8 and the data from bus bits 7:0. A read strobe returns the addressed register on bits 7:0. In the serial mode, bits shift in on the rising edge of the serial clock, and the rising edge of the write strobe commits the last eleven bits. One combination of the two select inputs is illegal. In that combination the block drives nothing and raises an error flag.

All inputs are sampled on the block clock. Strobe and serial-clock edges are found by comparing each input with its value in the previous cycle.

Top module: `ctlRegPort`

## Requirements
- R1: After reset the configuration word is 0, giving three-channel CCD mode with an internal 1 V reference. Every gain code is 0 (unity gain), and every offset code is C0h (zero offset).
- R2: With portSel=1 and outDisable=1, a rising edge of wrStrobe writes busIn[7:0] into the register addressed by busIn[10:8]. The new value appears on the outputs in the cycle after the edge is sampled.
- R3: The address map is: 0 = configuration (7 bits), 1/2/3 = red/green/blue offsets (8 bits), 4/5/6 = red/green/blue gains (5 bits), 7 = reserved. On the packed offsetCodes and gainCodes outputs, red is the lowest field.
- R4: With portSel=0, each rising edge of serClk shifts in serData. The frame is 11 bits, most significant first: address bit 2 down to bit 0, then data bit 7 down to bit 0. A rising edge of wrStrobe commits the frame as a write.
- R5: With portSel=1, outDisable=1 and rdStrobe high, the block drives bits 7:0 only (busDrive = 0FFh) with the addressed register. Unused upper bits of narrow registers read as zero.
- R6: Writes to address 7 change no register, and reads from address 7 return zero.
- R7: With outDisable=0 and portSel=0, the block drives all 12 bus bits with convData.
- R8: With outDisable=1 and portSel=0, the block drives no bus bit and modeError is low.
- R9: With outDisable=0 and portSel=1, the block drives no bus bit, modeError is high, and write strobes change no register.
- R10: The configuration fields decode as follows: bit 0 = CIS sensor (cfgSensorCis), bit 1 = 1.5 V reference (cfgRefHigh), bit 2 = external reference (cfgRefExt), bit 3 = single channel (cfgSingleCh), bits 5:4 = selected channel (cfgChanSel), bit 6 = reversed mux order (cfgOrderRev).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| portSel | input | 1 | 1 = parallel port, 0 = serial port |
| outDisable | input | 1 | 1 = converter output off |
| wrStrobe | input | 1 | Write strobe, rising edge commits |
| rdStrobe | input | 1 | Parallel read strobe, level active |
| serClk | input | 1 | Serial shift clock |
| serData | input | 1 | Serial data line |
| busIn | input | 11 | Bus value seen at the pins (address 10:8, data 7:0) |
| convData | input | 12 | Converter sample to place on the bus |
| busOut | output | 12 | Value driven onto the bus |
| busDrive | output | 12 | Per-bit drive enable for the bus |
| modeError | output | 1 | Illegal select combination |
| cfgSensorCis | output | 1 | Sensor type: 0 = CCD, 1 = CIS |
| cfgRefHigh | output | 1 | Reference voltage: 0 = 1 V, 1 = 1.5 V |
| cfgRefExt | output | 1 | Reference source: 0 = internal, 1 = external |
| cfgSingleCh | output | 1 | 0 = three channels, 1 = one channel |
| cfgChanSel | output | 2 | Channel used in single-channel mode |
| cfgOrderRev | output | 1 | Mux order: 0 = R,G,B; 1 = B,G,R |
| offsetCodes | output | 24 | Offset codes, red in bits 7:0 |
| gainCodes | output | 15 | Gain codes, red in bits 4:0 |

## Verification
The bench builds the block with its default parameters: three channels, 5-bit gains and a 12-bit converter. With these values, seven of the eight addresses are in use, so the reserved address and the zero-fill of narrow registers are both reachable. The read path also leaves bus bits 11:8 undriven. Random writes mix both ports across the whole address map. Directed cases cover the illegal select mode, the reserved address and converter ownership of the bus.

// File: rtl/ctlRegPkg.sv
package ctlRegPkg;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = ADDR_W + DATA_W;

  typedef struct packed {
    logic              wrEn;
    logic [ADDR_W-1:0] wrAddr;
    logic [DATA_W-1:0] wrData;
    logic              rdEn;
    logic [ADDR_W-1:0] rdAddr;
    logic              convEn;
    logic              modeErr;
  } portStrobe_t;
endpackage

// File: rtl/ctlRegSeq.sv
module ctlRegSeq
  import ctlRegPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               portSel,
  input  logic               outDisable,
  input  logic               wrStrobe,
  input  logic               rdStrobe,
  input  logic               serClk,
  input  logic               serData,
  input  logic [FRAME_W-1:0] busIn,
  output portStrobe_t        st
);
  logic               wrPrev;
  logic               sclkPrev;
  logic [FRAME_W-1:0] shiftReg;
  logic               parMode;
  logic               serMode;
  logic               wrRise;
  logic [FRAME_W-1:0] frame;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPrev   <= 1'b0;
      sclkPrev <= 1'b0;
      shiftReg <= '0;
    end else begin
      wrPrev   <= wrStrobe;
      sclkPrev <= serClk;
      if (serClk && !sclkPrev)
        shiftReg <= {shiftReg[FRAME_W-2:0], serData};
    end
  end

  always_comb begin
    parMode    = portSel && outDisable;
    serMode    = !portSel;
    wrRise     = wrStrobe && !wrPrev;
    frame      = parMode ? busIn : shiftReg;
    st.wrEn    = wrRise && (parMode || serMode);
    st.wrAddr  = frame[FRAME_W-1 -: ADDR_W];
    st.wrData  = frame[DATA_W-1:0];
    st.rdEn    = parMode && rdStrobe;
    st.rdAddr  = busIn[FRAME_W-1 -: ADDR_W];
    st.convEn  = serMode && !outDisable;
    st.modeErr = portSel && !outDisable;
  end

  // R9
  prohibited_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (portSel && !outDisable) |-> (!st.wrEn && !st.rdEn && !st.convEn));
endmodule

// File: rtl/ctlRegFile.sv
module ctlRegFile
  import ctlRegPkg::*;
#(
  parameter int          CH_N    = 3,
  parameter int          GAIN_W  = 5,
  parameter int          CFG_W   = 7,
  parameter int          CONV_W  = 12,
  parameter logic [7:0]  OFF_RST = 8'hC0
)(
  input  logic                     clk,
  input  logic                     rstN,
  input  portStrobe_t              st,
  input  logic [CONV_W-1:0]        convData,
  output logic [CFG_W-1:0]         cfgBits,
  output logic [CH_N*DATA_W-1:0]   offsetCodes,
  output logic [CH_N*GAIN_W-1:0]   gainCodes,
  output logic [CONV_W-1:0]        busOut,
  output logic [CONV_W-1:0]        busDrive
);
  localparam int OFF_BASE  = 1;
  localparam int GAIN_BASE = 1 + CH_N;
  localparam logic [ADDR_W-1:0] RSV_ADDR = ADDR_W'(2**ADDR_W - 1);
  localparam logic [CONV_W-1:0] RD_MASK  = CONV_W'({DATA_W{1'b1}});

  logic [CFG_W-1:0]  cfgReg;
  logic [DATA_W-1:0] rdData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      cfgReg <= '0;
    else if (st.wrEn && st.wrAddr == '0)
      cfgReg <= st.wrData[CFG_W-1:0];
  end
  assign cfgBits = cfgReg;

  for (genvar ch = 0; ch < CH_N; ch++) begin : g_chan
    logic [DATA_W-1:0] offReg;
    logic [GAIN_W-1:0] gainReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        offReg  <= OFF_RST;
        gainReg <= '0;
      end else if (st.wrEn) begin
        if (st.wrAddr == ADDR_W'(OFF_BASE + ch))
          offReg <= st.wrData;
        if (st.wrAddr == ADDR_W'(GAIN_BASE + ch))
          gainReg <= st.wrData[GAIN_W-1:0];
      end
    end
    assign offsetCodes[ch*DATA_W +: DATA_W] = offReg;
    assign gainCodes[ch*GAIN_W +: GAIN_W]   = gainReg;
  end

  always_comb begin
    rdData = '0;
    if (st.rdAddr == '0)
      rdData = DATA_W'(cfgReg);
    for (int ch = 0; ch < CH_N; ch++) begin
      if (st.rdAddr == ADDR_W'(OFF_BASE + ch))
        rdData = offsetCodes[ch*DATA_W +: DATA_W];
      if (st.rdAddr == ADDR_W'(GAIN_BASE + ch))
        rdData = DATA_W'(gainCodes[ch*GAIN_W +: GAIN_W]);
    end
  end

  always_comb begin
    busOut   = '0;
    busDrive = '0;
    if (st.convEn) begin
      busOut   = convData;
      busDrive = '1;
    end else if (st.rdEn) begin
      busOut   = CONV_W'(rdData);
      busDrive = RD_MASK;
    end
  end

  // R2
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrEn && st.wrAddr == '0) |=> cfgReg == $past(st.wrData[CFG_W-1:0]));
  // R6
  reserved_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrEn && st.wrAddr == RSV_ADDR) |=>
      ($stable(cfgReg) && $stable(offsetCodes) && $stable(gainCodes)));
  // R9
  error_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.modeErr |=> ($stable(cfgReg) && $stable(offsetCodes) && $stable(gainCodes)));
  // R7
  conv_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.convEn |-> (busDrive == '1 && busOut == convData));
  // R5
  read_upper_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.rdEn |-> (busDrive == RD_MASK && busOut[CONV_W-1:DATA_W] == '0));
endmodule

// File: rtl/ctlRegPort.sv
module ctlRegPort
  import ctlRegPkg::*;
#(
  parameter int         CH_N    = 3,
  parameter int         GAIN_W  = 5,
  parameter int         CONV_W  = 12,
  parameter logic [7:0] OFF_RST = 8'hC0
)(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   portSel,
  input  logic                   outDisable,
  input  logic                   wrStrobe,
  input  logic                   rdStrobe,
  input  logic                   serClk,
  input  logic                   serData,
  input  logic [FRAME_W-1:0]     busIn,
  input  logic [CONV_W-1:0]      convData,
  output logic [CONV_W-1:0]      busOut,
  output logic [CONV_W-1:0]      busDrive,
  output logic                   modeError,
  output logic                   cfgSensorCis,
  output logic                   cfgRefHigh,
  output logic                   cfgRefExt,
  output logic                   cfgSingleCh,
  output logic [1:0]             cfgChanSel,
  output logic                   cfgOrderRev,
  output logic [CH_N*DATA_W-1:0] offsetCodes,
  output logic [CH_N*GAIN_W-1:0] gainCodes
);
  localparam int CFG_W = 7;

  portStrobe_t      st;
  logic [CFG_W-1:0] cfgBits;

  ctlRegSeq u_seq (
    .clk(clk), .rstN(rstN), .portSel(portSel), .outDisable(outDisable),
    .wrStrobe(wrStrobe), .rdStrobe(rdStrobe), .serClk(serClk),
    .serData(serData), .busIn(busIn), .st(st)
  );

  ctlRegFile #(
    .CH_N(CH_N), .GAIN_W(GAIN_W), .CFG_W(CFG_W), .CONV_W(CONV_W),
    .OFF_RST(OFF_RST)
  ) u_file (
    .clk(clk), .rstN(rstN), .st(st), .convData(convData),
    .cfgBits(cfgBits), .offsetCodes(offsetCodes), .gainCodes(gainCodes),
    .busOut(busOut), .busDrive(busDrive)
  );

  assign modeError    = st.modeErr;
  assign cfgSensorCis = cfgBits[0];
  assign cfgRefHigh   = cfgBits[1];
  assign cfgRefExt    = cfgBits[2];
  assign cfgSingleCh  = cfgBits[3];
  assign cfgChanSel   = cfgBits[5:4];
  assign cfgOrderRev  = cfgBits[6];
endmodule

// File: tb/tb_ctlRegPort.sv
module tb_ctlRegPort;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rstN = 0;
  logic        portSel = 1, outDisable = 1, wrStrobe = 0, rdStrobe = 0;
  logic        serClk = 0, serData = 0;
  logic [10:0] busIn = '0;
  logic [11:0] convData = '0;
  logic [11:0] busOut, busDrive;
  logic        modeError, cfgSensorCis, cfgRefHigh, cfgRefExt, cfgSingleCh, cfgOrderRev;
  logic [1:0]  cfgChanSel;
  logic [23:0] offsetCodes;
  logic [14:0] gainCodes;

  int total = 0;
  int bad = 0;
  logic [7:0] mdl [8];

  ctlRegPort dut (
    .clk(clk), .rstN(rstN), .portSel(portSel), .outDisable(outDisable),
    .wrStrobe(wrStrobe), .rdStrobe(rdStrobe), .serClk(serClk), .serData(serData),
    .busIn(busIn), .convData(convData), .busOut(busOut), .busDrive(busDrive),
    .modeError(modeError), .cfgSensorCis(cfgSensorCis), .cfgRefHigh(cfgRefHigh),
    .cfgRefExt(cfgRefExt), .cfgSingleCh(cfgSingleCh), .cfgChanSel(cfgChanSel),
    .cfgOrderRev(cfgOrderRev), .offsetCodes(offsetCodes), .gainCodes(gainCodes)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] maskFor(input logic [2:0] a, input logic [7:0] d);
    if (a == 3'd0) return d & 8'h7F;
    if (a >= 3'd4 && a <= 3'd6) return d & 8'h1F;
    if (a == 3'd7) return 8'h00;
    return d;
  endfunction

  task automatic modelWrite(input logic [2:0] a, input logic [7:0] d);
    if (a != 3'd7) mdl[a] = maskFor(a, d);
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic pulseWr();
    tick(); wrStrobe = 1;
    tick(); wrStrobe = 0;
    tick();
  endtask

  task automatic parWrite(input logic [2:0] a, input logic [7:0] d);
    portSel = 1; outDisable = 1; busIn = {a, d};
    pulseWr();
  endtask

  task automatic serWrite(input logic [2:0] a, input logic [7:0] d, input logic od);
    logic [10:0] fr;
    fr = {a, d};
    portSel = 0; outDisable = od;
    for (int i = 10; i >= 0; i--) begin
      serData = fr[i];
      tick(); serClk = 1;
      tick(); serClk = 0;
    end
    pulseWr();
  endtask

  task automatic readCheck(input logic [2:0] a, input string req);
    portSel = 1; outDisable = 1; busIn = {a, 8'h00}; rdStrobe = 1;
    #1;
    check(req, {20'd0, busDrive}, 32'h0FF);
    check(req, {20'd0, busOut}, {24'd0, mdl[a]});
    rdStrobe = 0;
    #1;
  endtask

  task automatic outputsCheck(input string req);
    check({req, " cfg"}, {25'd0, cfgOrderRev, cfgChanSel, cfgSingleCh, cfgRefExt,
                          cfgRefHigh, cfgSensorCis}, {24'd0, mdl[0]});
    check({req, " offs"}, {8'd0, offsetCodes}, {8'd0, mdl[3], mdl[2], mdl[1]});
    check({req, " gains"}, {17'd0, gainCodes},
          {17'd0, mdl[6][4:0], mdl[5][4:0], mdl[4][4:0]});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd1234));
    mdl[0] = 8'h00; mdl[1] = 8'hC0; mdl[2] = 8'hC0; mdl[3] = 8'hC0;
    mdl[4] = 8'h00; mdl[5] = 8'h00; mdl[6] = 8'h00; mdl[7] = 8'h00;
    repeat (3) tick();
    rstN = 1;
    tick();

    // R1 reset state
    outputsCheck("R1 reset");
    check("R1 gains zero", {17'd0, gainCodes}, 32'd0);

    // R2 R3 R10 parallel config write, field decode
    parWrite(3'd0, 8'hFF); modelWrite(3'd0, 8'hFF);
    outputsCheck("R2 R10 cfg all ones");
    parWrite(3'd0, 8'h35); modelWrite(3'd0, 8'h35);
    check("R10 chanSel", {30'd0, cfgChanSel}, 32'd3);
    check("R10 singleCh/refExt", {30'd0, cfgSingleCh, cfgRefExt}, 32'd1);
    check("R10 sensor", {31'd0, cfgSensorCis}, 32'd1);
    parWrite(3'd2, 8'h5A); modelWrite(3'd2, 8'h5A);
    check("R3 green offset field", {24'd0, offsetCodes[15:8]}, 32'h5A);

    // R5 narrow readback
    parWrite(3'd5, 8'hFF); modelWrite(3'd5, 8'hFF);
    readCheck(3'd5, "R5 gain upper zero");
    readCheck(3'd0, "R5 cfg upper zero");

    // R4 serial frame
    serWrite(3'd6, 8'h13, 1'b1); modelWrite(3'd6, 8'h13);
    outputsCheck("R4 serial gain");
    serWrite(3'd1, 8'h81, 1'b0); modelWrite(3'd1, 8'h81);
    outputsCheck("R4 serial offset");

    // R6 reserved address
    parWrite(3'd7, 8'hAA);
    outputsCheck("R6 parallel reserved write");
    serWrite(3'd7, 8'h55, 1'b1);
    outputsCheck("R6 serial reserved write");
    readCheck(3'd7, "R6 reserved read");

    // R7 converter owns bus
    portSel = 0; outDisable = 0; convData = 12'hA5C; #1;
    check("R7 conv drive", {20'd0, busDrive}, 32'hFFF);
    check("R7 conv data", {20'd0, busOut}, 32'hA5C);
    check("R7 no error", {31'd0, modeError}, 32'd0);

    // R8 serial only, bus idle
    outDisable = 1; rdStrobe = 1; #1;
    check("R8 no drive", {20'd0, busDrive}, 32'd0);
    check("R8 no error", {31'd0, modeError}, 32'd0);
    rdStrobe = 0;

    // R9 prohibited mode
    portSel = 1; outDisable = 0; busIn = {3'd3, 8'h11}; rdStrobe = 1; #1;
    check("R9 no drive", {20'd0, busDrive}, 32'd0);
    check("R9 error flag", {31'd0, modeError}, 32'd1);
    rdStrobe = 0;
    pulseWr();
    readCheck(3'd3, "R9 write ignored");

    // R2 R4 random mix across both ports
    for (int n = 0; n < 120; n++) begin
      logic [2:0] a;
      logic [7:0] d;
      r = $urandom();
      a = r[2:0];
      d = r[15:8];
      if (r[16]) parWrite(a, d);
      else serWrite(a, d, r[17]);
      modelWrite(a, d);
      outputsCheck(r[16] ? "R2 random parallel" : "R4 random serial");
      if (r[20:18] == 3'd0) readCheck(r[23:21], "R5 random read");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule